// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block carries one logic level over a link that has no level wire, only two narrow-pulse lines: a "set" line and a "clear" line. The transmit half synchronizes its input and sends a one-clock pulse on the set line for a rising edge and on the clear line for a falling edge. When the input stays quiet for a programmable number of cycles, it sends the present level again as a refresh pulse. It repeats this for as long as the input stays idle, so the far side stays correct at DC.

The receive half keeps the level in a set/clear latch that holds between pulses. A cycle with both lines high is not a valid pulse and is ignored. A watchdog counts cycles without a valid pulse. When the timeout runs out, the watchdog raises a loss flag and forces the output to a fixed default level until the next valid pulse arrives.

The two halves share a clock in this block. The pulse lines come out of the transmit half and go into the receive half as separate ports, so the integrator decides what sits between them. The refresh interval (default 100 cycles) is well below the watchdog timeout (default 500 cycles), so a working transmitter never trips the watchdog.

Top module: `epc_codec`

## Requirements
- R1: `tx_din` passes through a two-flop synchronizer. A rise that `tx_din` presents before clock edge k gives `tx_set_line` = 1 in the cycle after edge k+2. A fall does the same on `tx_clr_line`.
- R2: Every transmit pulse is exactly one cycle wide, and `tx_set_line` and `tx_clr_line` are never high in the same cycle.
- R3: While the synchronized input is idle, the transmitter sends a pulse for the present level every `REFRESH_CYC` cycles: set for level 1, clear for level 0. An edge that falls in the cycle a refresh is due replaces the refresh, and the refresh timer restarts from every pulse sent.
- R4: A cycle with only `rx_set_line` high makes `rx_dout` 1 from the next cycle on. A cycle with only `rx_clr_line` high makes it 0. With neither line high, `rx_dout` holds.
- R5: A cycle with both receive lines high leaves `rx_dout` unchanged and does not restart the watchdog.
- R6: `WATCHDOG_CYC` captured cycles in a row without a valid pulse raise `rx_link_lost` and force `rx_dout` to `DEFAULT_LEVEL` (default 1) from the next cycle on. A valid pulse captured in that same cycle wins over the expiry.
- R7: The next valid pulse clears `rx_link_lost` and sets `rx_dout` to the level of that pulse.
- R8: During reset both transmit lines are 0, `rx_dout` equals `DEFAULT_LEVEL` and `rx_link_lost` is 0. After reset the output stays at the default until the first valid pulse.
- R9: With the transmit lines looped back to the receive lines, `rx_dout` equals `tx_din` from four cycles earlier, and `rx_link_lost` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_din | input | 1 | Level to transmit (asynchronous to clk) |
| tx_set_line | output | 1 | Transmit pulse: level is high |
| tx_clr_line | output | 1 | Transmit pulse: level is low |
| rx_set_line | input | 1 | Received set pulse |
| rx_clr_line | input | 1 | Received clear pulse |
| rx_dout | output | 1 | Recovered level |
| rx_link_lost | output | 1 | Watchdog expired, output forced to default |

## Verification
Two pairs of functions can land in the same cycle. On the transmit side, an input edge can arrive in the cycle a refresh is due. The bench times a toggle so that its edge meets the refresh slot exactly. It then checks that only the new-level pulse goes out and that the next refresh follows a full interval later. On the receive side, a valid pulse can arrive in the cycle the watchdog would expire. The bench injects a clear pulse at exactly the timeout count and checks that the flag stays low and the output stays low rather than taking the default. A random receive phase is judged against a bench model of the latch and watchdog, and a random loopback phase is judged against a four-cycle delay of the input.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } pulse_pair_t;

endpackage

// File: rtl/epc_sync.sv
module epc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/epc_tx.sv
module epc_tx
  import epc_pkg::*;
#(
  parameter int REFRESH_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_in,
  output pulse_pair_t lines
);

  localparam int RW = $clog2(REFRESH_CYC + 1);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);

  logic          lvl_s;
  logic          prev_q, prev_d;
  logic [RW-1:0] idle_q, idle_d;
  pulse_pair_t   lines_q, lines_d;
  logic          edge_hit, refresh_hit, fire;

  epc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (data_in),
    .q    (lvl_s)
  );

  always_comb begin
    edge_hit    = lvl_s ^ prev_q;
    refresh_hit = !edge_hit && (idle_q == REF_LAST);
    fire        = edge_hit || refresh_hit;
    prev_d      = lvl_s;
    idle_d      = fire ? '0 : idle_q + 1'b1;
    lines_d.set = fire && lvl_s;
    lines_d.clr = fire && !lvl_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      idle_q  <= '0;
      lines_q <= '0;
    end else begin
      prev_q  <= prev_d;
      idle_q  <= idle_d;
      lines_q <= lines_d;
    end
  end

  assign lines = lines_q;

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lines_q.set && lines_q.clr)); // R2
  AST_TX_SET_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    lines_q.set |=> !lines_q.set); // R2
  AST_TX_CLR_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    lines_q.clr |=> !lines_q.clr); // R2
  AST_TX_EDGE_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (lines_q.set == prev_q) && (lines_q.set != lines_q.clr)); // R1

endmodule

// File: rtl/epc_rx.sv
module epc_rx #(
  parameter int   WATCHDOG_CYC  = 500,
  parameter logic DEFAULT_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_in,
  output logic level_out,
  output logic lost_out
);

  localparam int WW = $clog2(WATCHDOG_CYC + 1);
  localparam logic [WW-1:0] WD_LAST = WW'(WATCHDOG_CYC - 1);

  logic          out_q, out_d;
  logic          lost_q, lost_d;
  logic [WW-1:0] wd_q, wd_d;
  logic          valid, expire;

  always_comb begin
    valid  = set_in ^ clr_in;
    expire = !valid && (wd_q == WD_LAST);
    out_d  = out_q;
    lost_d = lost_q;
    wd_d   = wd_q;
    if (valid) begin
      out_d  = set_in;
      lost_d = 1'b0;
      wd_d   = '0;
    end else if (expire) begin
      out_d  = DEFAULT_LEVEL;
      lost_d = 1'b1;
    end else begin
      wd_d   = wd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= DEFAULT_LEVEL;
      lost_q <= 1'b0;
      wd_q   <= '0;
    end else begin
      out_q  <= out_d;
      lost_q <= lost_d;
      wd_q   <= wd_d;
    end
  end

  assign level_out = out_q;
  assign lost_out  = lost_q;

  AST_RX_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && !clr_in) |=> level_out); // R4
  AST_RX_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && !set_in) |=> !level_out); // R4
  AST_RX_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && clr_in && !expire) |=> $stable(level_out)); // R5
  AST_RX_LOST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    lost_out |-> (level_out == DEFAULT_LEVEL)); // R6
  AST_RX_PULSE_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in ^ clr_in) |=> !lost_out); // R7

endmodule

// File: rtl/epc_codec.sv
module epc_codec
  import epc_pkg::*;
#(
  parameter int   REFRESH_CYC   = 100,
  parameter int   WATCHDOG_CYC  = 500,
  parameter logic DEFAULT_LEVEL = 1'b1,
  parameter int   SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_din,
  output logic tx_set_line,
  output logic tx_clr_line,
  input  logic rx_set_line,
  input  logic rx_clr_line,
  output logic rx_dout,
  output logic rx_link_lost
);

  pulse_pair_t tx_lines;

  epc_tx #(
    .REFRESH_CYC(REFRESH_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_in(tx_din),
    .lines  (tx_lines)
  );

  assign tx_set_line = tx_lines.set;
  assign tx_clr_line = tx_lines.clr;

  epc_rx #(
    .WATCHDOG_CYC (WATCHDOG_CYC),
    .DEFAULT_LEVEL(DEFAULT_LEVEL)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_in   (rx_set_line),
    .clr_in   (rx_clr_line),
    .level_out(rx_dout),
    .lost_out (rx_link_lost)
  );

  AST_R8_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!tx_set_line && !tx_clr_line && !rx_link_lost)); // R8

endmodule

// File: tb/epc_codec_tb.sv
module epc_codec_tb_top;

  localparam int   REF = 100;
  localparam int   WD  = 500;
  localparam logic DEF = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic inj = 1'b0;
  logic i_set = 1'b0;
  logic i_clr = 1'b0;
  logic tset, tclr, dout, lost;
  logic rset, rclr;

  int checks = 0;
  int errors = 0;

  assign rset = inj ? i_set : tset;
  assign rclr = inj ? i_clr : tclr;

  always #2 clk = ~clk;

  epc_codec #(
    .REFRESH_CYC  (REF),
    .WATCHDOG_CYC (WD),
    .DEFAULT_LEVEL(DEF),
    .SYNC_STAGES  (2)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_din      (din),
    .tx_set_line (tset),
    .tx_clr_line (tclr),
    .rx_set_line (rset),
    .rx_clr_line (rclr),
    .rx_dout     (dout),
    .rx_link_lost(lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(tset || tclr) && n < 10000);
  endtask

  task automatic pulse1(input logic s, input logic c);
    i_set = s;
    i_clr = c;
    @(negedge clk);
    i_set = 1'b0;
    i_clr = 1'b0;
  endtask

  // Receiver expectation from R4..R7: quiet counts captured cycles without a valid pulse
  function automatic void rx_model(input logic s, input logic c,
                                   inout logic o, inout logic l, inout int quiet);
    if (s ^ c) begin
      o = s;
      l = 1'b0;
      quiet = 0;
    end else begin
      if (quiet < WD) quiet++;
      if (quiet >= WD) begin
        l = 1'b1;
        o = DEF;
      end
    end
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] hist;
    int hold;
    logic m_out, m_lost;
    int m_q;
    void'($urandom(32'h00C0_DEC5));

    // reset state
    repeat (3) @(negedge clk);
    chk("R8 set line", tset, 0);
    chk("R8 clr line", tclr, 0);
    chk("R8 dout", dout, DEF);
    chk("R8 lost", lost, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 dout after release", dout, DEF);

    // first refresh carries level 0, then steady interval
    wait_pulse(n);
    chk("R3 first refresh is clr", tclr, 1);
    chk("R3 first refresh not set", tset, 0);
    wait_pulse(n);
    chk("R3 refresh interval", n, REF);
    chk("R4 dout follows clr", dout, 0);

    // rising edge latency
    din = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no early set", tset, 0);
    @(negedge clk);
    chk("R1 set pulse", tset, 1);
    chk("R1 no clr on rise", tclr, 0);
    @(negedge clk);
    chk("R2 set one cycle", tset, 0);
    chk("R9 dout rise", dout, 1);

    // falling edge latency
    din = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 no early clr", tclr, 0);
    @(negedge clk);
    chk("R1 clr pulse", tclr, 1);
    chk("R1 no set on fall", tset, 0);
    @(negedge clk);
    chk("R2 clr one cycle", tclr, 0);
    chk("R9 dout fall", dout, 0);

    // edge lands exactly on refresh slot
    wait_pulse(n);
    chk("R3 refresh after edge", n, REF - 1);
    repeat (REF - 3) @(negedge clk);
    din = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 collision sends set", tset, 1);
    chk("R3 collision no clr", tclr, 0);
    repeat (REF - 1) @(negedge clk);
    chk("R3 no pulse before restart", int'(tset | tclr), 0);
    @(negedge clk);
    chk("R3 refresh after restart", tset, 1);

    // random loopback
    hist = {4{din}};
    hold = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R9 loopback level", dout, hist[3]);
      chk("R9 no loss in loopback", lost, 0);
      chk("R2 lines exclusive", int'(tset & tclr), 0);
      if (hold == 0) begin
        din = 1'($urandom);
        hold = $urandom_range(1, 150);
      end
      hold--;
      hist = {hist[2:0], din};
    end

    // receiver directed cases
    @(negedge clk);
    inj = 1'b1;
    pulse1(1'b1, 1'b0);
    chk("R4 set drives high", dout, 1);
    pulse1(1'b0, 1'b1);
    chk("R4 clr drives low", dout, 0);
    repeat (8) @(negedge clk);
    chk("R4 holds between pulses", dout, 0);
    pulse1(1'b1, 1'b1);
    chk("R5 both ignored", dout, 0);
    repeat (WD - 10) @(negedge clk);
    chk("R5 both did not restart watchdog, not yet", lost, 0);
    @(negedge clk);
    chk("R6 lost raised", lost, 1);
    chk("R6 dout default", dout, DEF);
    pulse1(1'b1, 1'b0);
    chk("R7 lost cleared", lost, 0);
    chk("R7 dout from pulse", dout, 1);
    pulse1(1'b0, 1'b1);
    chk("R7 dout low", dout, 0);
    repeat (WD - 1) @(negedge clk);
    pulse1(1'b0, 1'b1);
    chk("R6 pulse beats expiry lost", lost, 0);
    chk("R6 pulse beats expiry dout", dout, 0);

    // random receiver phase against model
    pulse1(1'b0, 1'b1);
    m_out = 1'b0;
    m_lost = 1'b0;
    m_q = 0;
    for (int i = 0; i < 8000; i++) begin
      logic s, c;
      chk("R6 model dout", dout, m_out);
      chk("R7 model lost", lost, m_lost);
      s = 1'b0;
      c = 1'b0;
      if ($urandom_range(0, 599) == 0) begin
        case ($urandom_range(0, 2))
          0: s = 1'b1;
          1: c = 1'b1;
          default: begin s = 1'b1; c = 1'b1; end
        endcase
      end
      i_set = s;
      i_clr = c;
      rx_model(s, c, m_out, m_lost, m_q);
      @(negedge clk);
    end
    i_set = 1'b0;
    i_clr = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule